// File: doc/BRIEF.md
# Strip-Descriptor Display Sequencer

This block schedules every scan line of a character overlay. A frame is not a fixed text grid. It is a chain of strips, and each strip is described by one 16-bit descriptor word in a shared memory. A spacing strip produces a run of empty scan lines, which are either black or transparent. A character strip produces a band of text rows. Each character strip has its own vertical zoom and its own visibility. The sequencer walks the chain of descriptors after each frame sync. For each character line it fetches character codes from memory and tells the font stage which slice of the glyph to draw. It also raises a display window that covers the pixels carrying glyph data.

Horizontal timing is derived on the pixel clock:

- A line lasts (LD+1)×12 pixel periods, or ends earlier when a rising H-SYNC realigns it.
- The left margin is (DD+8)×3 pixel periods.
- Each character cell is 12 pixels wide.

The state machine has seven states:

| State | Meaning |
|---|---|
| S_IDLE | Waits after reset until the first frame sync. |
| S_DFETCH | Reads a descriptor. |
| S_DDECODE | Loads the descriptor fields. |
| S_SPACE | Spacing lines. |
| S_CWAIT | Character line, before the active area. |
| S_CACT | Character cells being shown. |
| S_CREST | Rest of the line after an end-of-line code. |

The transitions are:

- **Restart:** from any state to S_DFETCH on a line start that has a pending V-SYNC fall.
- **Fetch:** S_DFETCH to S_DDECODE.
- **Decode:** S_DDECODE goes to S_SPACE or S_CWAIT. A strip with a line count of zero goes straight back to S_DFETCH.
- **Line advance:** on a line start inside a strip, the block goes to S_DFETCH after the strip's last line. Otherwise it stays in S_SPACE, or returns to S_CWAIT for a character strip.
- **First code:** in S_CWAIT, the first code read goes to S_CACT, or to S_CREST if it is the end-of-line code.
- **End of line:** S_CACT goes to S_CREST on an end-of-line code.

Top module: `strip_seq`

## Requirements
- R1: After reset, until the first V-SYNC falling edge, the block issues no memory read, and disp_en and space_line stay low, whatever H-SYNC does.
- R2: After a V-SYNC falling edge, at the next line start the block reads a descriptor at address page×64. The page value is cfg_page placed in address bits 8:6, with bits 5:0 at zero. Later descriptors are read at successive addresses. Each read issues mem_rd_en in the first pixel cycle of the line, and data returns one cycle later.
- R3: Descriptor encoding: bit 15 selects the kind (1 = character, 0 = spacing). For a character strip, bit 14 is show, bit 13 is zoom, and bits 9:0 are the first code address. For a spacing strip, bit 14 is transparent and bits 7:0 are the line count.
- R4: A spacing strip gives exactly its line count of lines. On those lines space_line is 1, space_transp equals its bit 14, and disp_en is 0. A count of 0 is skipped within the same line.
- R5: A character strip lasts cfg_char_h×(1+zoom) lines. When that product is 0 the strip is skipped within the same line.
- R6: On a character line, slice_idx runs from 0 to cfg_char_h−1. With zoom set, each slice value holds for two consecutive lines.
- R7: On each line of a shown character strip, codes are read from the strip's first code address at successive addresses. The first read comes two cycles before the active start. Each code drives char_code for 12 pixel cycles of disp_en.
- R8: A code of 0x00 in bits 7:0 ends the line's text. No further code is read and disp_en stays low until the line ends. A line therefore shows 12 disp_en cycles per code before the end code.
- R9: line_start pulses once every (cfg_line_dur+1)×12 cycles. A rising H-SYNC starts a new line in the cycle it rises.
- R10: disp_en first rises at pixel (cfg_left_dly+8)×3 of the line. It is cut at the last pixel of the line.
- R11: A strip with show = 0 keeps its full line count but issues no code read and keeps disp_en low.
- R12: A V-SYNC fall in the middle of a strip abandons that strip at the next line start. If the fall comes in the same cycle as a line start, the restart happens at that line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; a rising edge starts a line |
| vsync | input | 1 | Vertical sync; a falling edge restarts the frame |
| cfg_page | input | 3 | Descriptor table select |
| cfg_char_h | input | 6 | Character height in slices |
| cfg_line_dur | input | 6 | Line length setting, (value+1)×12 pixels |
| cfg_left_dly | input | 8 | Left margin setting, (value+8)×3 pixels; at least 4 |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd_en |
| line_start | output | 1 | High in the last cycle of each line |
| space_line | output | 1 | Current line belongs to a spacing strip |
| space_transp | output | 1 | Current spacing line is transparent |
| slice_idx | output | 6 | Font slice for the current character line |
| char_code | output | 8 | Character code being shown |
| disp_en | output | 1 | Display window for glyph pixels |

## Verification
The delicate collision is a V-SYNC fall landing in the very cycle that ends a line. That cycle may also be the cycle where a strip would advance to its next line or fetch its next descriptor. The bench provokes this by counting pixel cycles from an observed line start and dropping V-SYNC exactly in the final pixel of a line. The collision is judged correct when the following line fetches its descriptor at the table base in its first cycle. That line must also behave as frame line 0 of the table, rather than continuing the interrupted strip. Mid-strip falls at other points of a line are mixed in as well, to show that the interrupted strip does not leak into the restarted frame.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DFETCH,
        S_DDECODE,
        S_SPACE,
        S_CWAIT,
        S_CACT,
        S_CREST
    } seq_state_t;

    // character cell geometry
    localparam int CELL_W   = 12;
    localparam int CELL_RD  = CELL_W - 2;   // cell pixel at which the next code is requested
    localparam int LINE_MUL = 12;
    localparam int MRG_OFS  = 8;
    localparam int MRG_MUL  = 3;

endpackage

// File: rtl/strip_seq_edges.sv
module strip_seq_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    output logic hs_rise,
    output logic vs_fall
);

    logic hs_q;
    logic vs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
        end
    end

    assign hs_rise = hsync & ~hs_q;
    assign vs_fall = vs_q & ~vsync;

endmodule

// File: rtl/strip_seq_timer.sv
module strip_seq_timer import strip_seq_pkg::*; #(
    parameter int LD_W = 6,
    parameter int DD_W = 8,
    parameter int PX_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hs_rise,
    input  logic [LD_W-1:0] cfg_line_dur,
    input  logic [DD_W-1:0] cfg_left_dly,
    output logic            line_start,
    output logic            code_pt
);

    logic [PX_W-1:0] px_q;
    logic [PX_W-1:0] len_m1;
    logic [PX_W-1:0] margin;

    assign len_m1 = (PX_W'(cfg_line_dur) + PX_W'(1)) * PX_W'(LINE_MUL) - PX_W'(1);
    assign margin = (PX_W'(cfg_left_dly) + PX_W'(MRG_OFS)) * PX_W'(MRG_MUL);

    assign line_start = hs_rise | (px_q == len_m1);
    assign code_pt    = (px_q == margin - PX_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          px_q <= '0;
        else if (line_start) px_q <= '0;
        else                 px_q <= px_q + PX_W'(1);
    end

endmodule

// File: rtl/strip_seq_fsm.sv
module strip_seq_fsm import strip_seq_pkg::*; #(
    parameter int AW       = 10,
    parameter int DW       = 16,
    parameter int PAGE_W   = 3,
    parameter int PAGE_SH  = 6,
    parameter int CH_W     = 6,
    parameter int CNT_W    = 8,
    parameter int CODE_W   = 8,
    parameter int EOL_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              vs_fall,
    input  logic              code_pt,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [CH_W-1:0]   cfg_char_h,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              space_line,
    output logic              space_transp,
    output logic [CH_W-1:0]   slice_idx,
    output logic [CODE_W-1:0] char_code,
    output logic              disp_en
);

    localparam int CPX_W   = $clog2(CELL_W);
    localparam int KIND_B  = DW - 1;
    localparam int FLAG_B  = DW - 2;
    localparam int ZOOM_B  = DW - 3;

    seq_state_t state, nxt;

    logic [AW-1:0]     desc_ptr, code_base, code_ptr;
    logic [CNT_W-1:0]  line_cnt, line_tot, new_tot;
    logic [CPX_W-1:0]  ch_px;
    logic [CODE_W-1:0] code_q;
    logic              flag_q, zoom_q, rd_q, restart_q;
    logic              restart, in_strip, advance, last_line, eol_hit, code_rd, d_kind, d_zoom;

    assign restart   = line_start & (restart_q | vs_fall);
    assign in_strip  = (state == S_SPACE) | (state == S_CWAIT) | (state == S_CACT) | (state == S_CREST);
    assign advance   = line_start & in_strip & ~restart;
    assign last_line = (line_cnt == line_tot - CNT_W'(1));
    assign eol_hit   = rd_q & (mem_rdata[CODE_W-1:0] == CODE_W'(EOL_CODE));
    assign d_kind    = mem_rdata[KIND_B];
    assign d_zoom    = d_kind & mem_rdata[ZOOM_B];
    assign new_tot   = d_kind ? (d_zoom ? CNT_W'({cfg_char_h, 1'b0}) : CNT_W'(cfg_char_h))
                              : mem_rdata[CNT_W-1:0];
    assign code_rd   = ((state == S_CWAIT) & flag_q & code_pt & ~rd_q)
                     | ((state == S_CACT) & (ch_px == CPX_W'(CELL_RD)));

    // next-state selection
    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = S_DFETCH;
        end else if (advance) begin
            nxt = last_line ? S_DFETCH : ((state == S_SPACE) ? S_SPACE : S_CWAIT);
        end else begin
            unique case (state)
                S_IDLE:    nxt = S_IDLE;
                S_DFETCH:  nxt = S_DDECODE;
                S_DDECODE: nxt = (new_tot == '0) ? S_DFETCH : (d_kind ? S_CWAIT : S_SPACE);
                S_SPACE:   nxt = S_SPACE;
                S_CWAIT:   nxt = rd_q ? (eol_hit ? S_CREST : S_CACT) : S_CWAIT;
                S_CACT:    nxt = eol_hit ? S_CREST : S_CACT;
                S_CREST:   nxt = S_CREST;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // strip bookkeeping and code pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            rd_q      <= 1'b0;
            desc_ptr  <= '0;
            code_base <= '0;
            code_ptr  <= '0;
            line_cnt  <= '0;
            line_tot  <= '0;
            flag_q    <= 1'b0;
            zoom_q    <= 1'b0;
            ch_px     <= '0;
            code_q    <= '0;
        end else begin
            restart_q <= (restart_q | vs_fall) & ~line_start;
            rd_q      <= code_rd & ~line_start;
            if (restart)
                desc_ptr <= AW'({cfg_page, {PAGE_SH{1'b0}}});
            else if (state == S_DFETCH)
                desc_ptr <= desc_ptr + AW'(1);
            if (state == S_DDECODE && !restart) begin
                line_cnt  <= '0;
                line_tot  <= new_tot;
                flag_q    <= mem_rdata[FLAG_B];
                zoom_q    <= d_zoom;
                code_base <= mem_rdata[AW-1:0];
                code_ptr  <= mem_rdata[AW-1:0];
            end else if (advance) begin
                line_cnt <= line_cnt + CNT_W'(1);
                code_ptr <= code_base;
            end else if (code_rd) begin
                code_ptr <= code_ptr + AW'(1);
            end
            if (rd_q && !eol_hit) begin
                code_q <= mem_rdata[CODE_W-1:0];
                ch_px  <= '0;
            end else if (state == S_CACT) begin
                ch_px <= ch_px + CPX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_en    = (state == S_DFETCH) | code_rd;
        mem_addr     = (state == S_DFETCH) ? desc_ptr : code_ptr;
        space_line   = (state == S_SPACE);
        space_transp = (state == S_SPACE) & flag_q;
        disp_en      = (state == S_CACT);
        char_code    = code_q;
        slice_idx    = '0;
        if (state == S_CWAIT || state == S_CACT || state == S_CREST)
            slice_idx = zoom_q ? line_cnt[CH_W:1] : line_cnt[CH_W-1:0];
    end

endmodule

// File: rtl/strip_seq.sv
module strip_seq import strip_seq_pkg::*; #(
    parameter int AW       = 10,
    parameter int DW       = 16,
    parameter int PAGE_W   = 3,
    parameter int PAGE_SH  = 6,
    parameter int CH_W     = 6,
    parameter int LD_W     = 6,
    parameter int DD_W     = 8,
    parameter int CODE_W   = 8,
    parameter int EOL_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [CH_W-1:0]   cfg_char_h,
    input  logic [LD_W-1:0]   cfg_line_dur,
    input  logic [DD_W-1:0]   cfg_left_dly,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              line_start,
    output logic              space_line,
    output logic              space_transp,
    output logic [CH_W-1:0]   slice_idx,
    output logic [CODE_W-1:0] char_code,
    output logic              disp_en
);

    localparam int LEN_MAX = (1 << LD_W) * LINE_MUL;
    localparam int MRG_MAX = ((1 << DD_W) - 1 + MRG_OFS) * MRG_MUL;
    localparam int PX_W    = $clog2((LEN_MAX > MRG_MAX) ? LEN_MAX : MRG_MAX) + 1;
    localparam int CNT_W   = CH_W + 2;

    logic hs_rise, vs_fall, code_pt;

    strip_seq_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync   (hsync),
        .vsync   (vsync),
        .hs_rise (hs_rise),
        .vs_fall (vs_fall)
    );

    strip_seq_timer #(.LD_W(LD_W), .DD_W(DD_W), .PX_W(PX_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_rise      (hs_rise),
        .cfg_line_dur (cfg_line_dur),
        .cfg_left_dly (cfg_left_dly),
        .line_start   (line_start),
        .code_pt      (code_pt)
    );

    strip_seq_fsm #(
        .AW(AW), .DW(DW), .PAGE_W(PAGE_W), .PAGE_SH(PAGE_SH), .CH_W(CH_W),
        .CNT_W(CNT_W), .CODE_W(CODE_W), .EOL_CODE(EOL_CODE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .vs_fall      (vs_fall),
        .code_pt      (code_pt),
        .cfg_page     (cfg_page),
        .cfg_char_h   (cfg_char_h),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .space_line   (space_line),
        .space_transp (space_transp),
        .slice_idx    (slice_idx),
        .char_code    (char_code),
        .disp_en      (disp_en)
    );

endmodule

// File: rtl/strip_seq_checker.sv
module strip_seq_checker #(
    parameter int AW      = 10,
    parameter int PAGE_W  = 3,
    parameter int PAGE_SH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync,
    input logic [PAGE_W-1:0] cfg_page,
    input logic              line_start,
    input logic              mem_rd_en,
    input logic [AW-1:0]     mem_addr,
    input logic              space_line,
    input logic              space_transp,
    input logic              disp_en
);

    logic          vs_q, pend, seen;
    logic [AW-1:0] base_q;
    logic          vsf;

    assign vsf = vs_q & ~vsync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q   <= 1'b0;
            pend   <= 1'b0;
            seen   <= 1'b0;
            base_q <= '0;
        end else begin
            vs_q   <= vsync;
            pend   <= (pend | vsf) & ~line_start;
            seen   <= seen | vsf;
            base_q <= AW'({cfg_page, {PAGE_SH{1'b0}}});
        end
    end

    // R1: silent until the first frame sync
    a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !mem_rd_en);

    // R2 / R12: a line start with a pending frame sync fetches the table base next cycle
    a_r2_restart_base: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (pend || vsf)) |=> (mem_rd_en && mem_addr == base_q));

    // R4: spacing lines never open the display window
    a_r4_space_dark: assert property (@(posedge clk) disable iff (!rst_n)
        space_line |-> !disp_en);

    // R4: transparency only qualifies spacing lines
    a_r4_transp_sub: assert property (@(posedge clk) disable iff (!rst_n)
        space_transp |-> space_line);

    // R7: the window opens two cycles after the first code request
    a_r7_read_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> $past(mem_rd_en, 2));

    // R9: line boundaries never occur back to back
    a_r9_line_gap: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

endmodule

bind strip_seq strip_seq_checker #(.AW(AW), .PAGE_W(PAGE_W), .PAGE_SH(PAGE_SH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync        (vsync),
    .cfg_page     (cfg_page),
    .line_start   (line_start),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .space_line   (space_line),
    .space_transp (space_transp),
    .disp_en      (disp_en)
);

// File: tb/strip_seq_bench.sv
module strip_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic [2:0]  cfg_page = '0;
    logic [5:0]  cfg_char_h = 6'd2;
    logic [5:0]  cfg_line_dur = 6'd4;
    logic [7:0]  cfg_left_dly = 8'd4;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        line_start, space_line, space_transp, disp_en;
    logic [5:0]  slice_idx;
    logic [7:0]  char_code;

    logic [15:0] mem [0:1023];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected per-line values
    int e_kind [0:255];
    int e_transp [0:255];
    int e_slice [0:255];
    int e_disp [0:255];
    int e_code [0:255];
    int e_nrd [0:255];
    int e_lines;
    int di;
    int len, margin, page, ch;

    always #4 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    strip_seq u_strip_seq (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .cfg_page(cfg_page), .cfg_char_h(cfg_char_h),
        .cfg_line_dur(cfg_line_dur), .cfg_left_dly(cfg_left_dly),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .line_start(line_start), .space_line(space_line), .space_transp(space_transp),
        .slice_idx(slice_idx), .char_code(char_code), .disp_en(disp_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic set_cfg(input int ld, input int dd, input int pg, input int chh);
        cfg_line_dur = 6'(ld);
        cfg_left_dly = 8'(dd);
        cfg_page     = 3'(pg);
        cfg_char_h   = 6'(chh);
        len    = (ld + 1) * 12;
        margin = (dd + 8) * 3;
        page   = pg;
        ch     = chh;
        e_lines = 0;
        di      = 0;
    endtask

    task automatic add_space(input int sl, input int tr);
        mem[page * 64 + di] = {1'b0, 1'(tr), 6'd0, 8'(sl)};
        di++;
        for (int l = 0; l < sl; l++) begin
            e_kind[e_lines] = 0; e_transp[e_lines] = tr; e_slice[e_lines] = 0;
            e_disp[e_lines] = 0; e_code[e_lines] = -1; e_nrd[e_lines] = 0;
            e_lines++;
        end
    endtask

    task automatic add_char(input int n, input int zy, input int de);
        int base;
        int nrd;
        base = 512 + di * 16;
        mem[page * 64 + di] = {1'b1, 1'(de), 1'(zy), 3'd0, 10'(base)};
        for (int i = 0; i < n; i++) mem[base + i] = 16'(1 + ($urandom % 255));
        mem[base + n] = 16'h0000;
        nrd = 0;
        for (int k = 0; k <= n; k++) if (margin - 2 + 12 * k <= len - 1) nrd++;
        for (int l = 0; l < ch * (1 + zy); l++) begin
            e_kind[e_lines]   = 1;
            e_transp[e_lines] = 0;
            e_slice[e_lines]  = zy ? l / 2 : l;
            e_disp[e_lines]   = de ? min2(12 * n, len - margin) : 0;
            e_code[e_lines]   = (de && n > 0) ? int'(mem[base][7:0]) : -1;
            e_nrd[e_lines]    = de ? nrd : 0;
            e_lines++;
        end
        di++;
    endtask

    task automatic finish_table();
        mem[page * 64 + di] = {1'b0, 1'b0, 6'd0, 8'd255};
    endtask

    task automatic drop_vsync();
        @(posedge clk); #1 vsync = 1'b1;
        repeat (3) @(posedge clk);
        #1 vsync = 1'b0;
    endtask

    // waits for the first line start, then checks k lines against the model
    task automatic check_lines(input int k);
        bit got;
        got = 0;
        while (!got) begin @(negedge clk); got = line_start; end
        for (int ln = 0; ln < k; ln++) begin
            int pxc = 0, cnt = 0, first = -1, code = -1, nrd = 0, sp = 0, tr = 0, sl = 0;
            bit done = 0;
            while (!done) begin
                @(negedge clk);
                if (ln == 0 && pxc == 0)
                    chk(mem_rd_en && mem_addr == 10'(page * 64), "R2 base fetch",
                        int'(mem_addr), page * 64);
                if (disp_en) begin
                    if (first < 0) begin first = pxc; code = int'(char_code); end
                    cnt++;
                end
                if (mem_rd_en && mem_addr >= 10'd512) nrd++;
                if (pxc == 20) begin sp = int'(space_line); tr = int'(space_transp); sl = int'(slice_idx); end
                if (line_start) done = 1; else pxc++;
            end
            chk(pxc == len - 1, "R9 line length", pxc + 1, len);
            if (e_kind[ln] == 0) begin
                chk(sp == 1, "R4 spacing line", sp, 1);
                chk(tr == e_transp[ln], "R3 transparent flag", tr, e_transp[ln]);
                chk(cnt == 0, "R4 spacing dark", cnt, 0);
            end else begin
                chk(sp == 0, "R5 character line", sp, 0);
                chk(sl == e_slice[ln], "R6 slice", sl, e_slice[ln]);
                if (e_nrd[ln] == 0)
                    chk(cnt == 0 && nrd == 0, "R11 hidden strip", cnt + nrd, 0);
                else begin
                    chk(cnt == e_disp[ln], "R8 window length", cnt, e_disp[ln]);
                    chk(nrd == e_nrd[ln], "R7 code reads", nrd, e_nrd[ln]);
                end
                if (e_disp[ln] > 0) begin
                    chk(first == margin, "R10 active start", first, margin);
                    chk(code == e_code[ln], "R7 first code", code, e_code[ln]);
                end
            end
        end
    endtask

    task automatic random_table();
        int ld, dd, mx;
        ld = 3 + $urandom % 7;
        mx = ((ld + 1) * 12 - 6) / 3 - 8;
        dd = 4 + $urandom % (mx - 3);
        set_cfg(ld, dd, $urandom % 8, $urandom % 4);
        for (int s = 0; s < 4; s++) begin
            if ($urandom % 2) add_space($urandom % 4, $urandom % 2);
            else add_char($urandom % 7, $urandom % 2, ($urandom % 4) != 0);
        end
        finish_table();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset, H-SYNC alone starts nothing
        begin
            int rd = 0, de = 0, sp = 0;
            for (int c = 0; c < 300; c++) begin
                @(posedge clk); #1 hsync = (c % 70) < 3;
                @(negedge clk);
                rd += int'(mem_rd_en); de += int'(disp_en); sp += int'(space_line);
            end
            hsync = 1'b0;
            chk(rd == 0, "R1 no read before sync", rd, 0);
            chk(de + sp == 0, "R1 outputs idle", de + sp, 0);
        end

        // directed frame: clipping, early end code, zero-count skip, hidden strip
        set_cfg(4, 4, 3, 2);
        add_space(2, 1);
        add_char(3, 1, 1);
        add_space(0, 0);
        add_char(0, 0, 1);
        add_char(5, 0, 1);
        add_char(2, 0, 0);
        finish_table();
        drop_vsync();
        check_lines(e_lines);

        // R9: H-SYNC rise realigns the line
        begin
            int gap = 0;
            bit got = 0;
            while (!got) begin @(negedge clk); got = line_start; end
            repeat (10) @(posedge clk);
            #1 hsync = 1'b1;
            @(negedge clk);
            chk(line_start == 1'b1, "R9 hsync line start", int'(line_start), 1);
            @(posedge clk); #1 hsync = 1'b0;
            got = 0;
            while (!got) begin @(negedge clk); gap++; got = line_start; end
            chk(gap == len, "R9 period after hsync", gap, len);
        end

        // random frames
        for (int f = 0; f < 6; f++) begin
            random_table();
            drop_vsync();
            check_lines(e_lines);
        end

        // R12: frame sync in the middle of a strip
        random_table();
        drop_vsync();
        check_lines(e_lines / 2);
        drop_vsync();
        check_lines(e_lines);

        // R12: frame sync in the last pixel of a line
        begin
            bit got = 0;
            #1 vsync = 1'b1;
            while (!got) begin @(negedge clk); got = line_start; end
            repeat (len) @(posedge clk);
            #1 vsync = 1'b0;
            check_lines(e_lines);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule